// File: doc/BRIEF.md
# Activation-Gated Power-Down Control Register

This block is the host-facing register slice of a bus peripheral. It watches host I/O cycles and decides which ones fall inside the peripheral's 16-byte register window. The address compare is either full, over all 16 address lines, or reduced, over the low 10 lines only. A static configuration bit chooses between them. A logical-device activate bit gates all register accesses and boot-ROM reads. While that bit is clear, only the halt-clock register still answers.

The halt-clock register is write-only. Its value picks the power-down mode through a two-state machine with states `PM_RUN` and `PM_HALT`:

- Transition `T_HALT` (`PM_RUN` to `PM_HALT`) is taken on a valid write of 48h.
- Transition `T_WAKE` (`PM_HALT` to `PM_RUN`) is taken on a valid write of 52h.
- Transition `T_FORCE` (`PM_HALT` to `PM_RUN`) is taken whenever the power-down enable bit is clear. It has priority over writes.

A write is valid only while the power-down enable bit is 1. The machine drives a clock-halt request and a clock-running indication. An external clock gating cell consumes them.

Top module: `hostreg_pwrctl`

## Requirements
- R1: After reset the mode is `PM_RUN`: `clk_halt_req`=0, `clk_running`=1.
- R2: `act_n` always equals the inverse of `pnp_act`. A read of the status register at offset 03h returns bit 0 = ~`pnp_act` and bit 1 = 1 when in `PM_HALT`. All other bits of that register are 0.
- R3: When `cfg_full_dec`=1, `io_addr[15:4]` must equal `BASE_ADDR[15:4]` to hit. When it is 0, only `io_addr[9:4]` is compared. The low 4 bits are the register offset.
- R4: While `pnp_act`=0, `rom_rd_en` is 0 and every I/O access that misses offset 09h is not claimed (`io_claim`=0) and reads 0. While `pnp_act`=1, `rom_rd_en` follows `rom_rd`.
- R5: A write to offset 09h with `cfg_pwrdn`=1 takes effect at the next clock edge. A value of 48h enters `PM_HALT` (`clk_halt_req`=1, `clk_running`=0). A value of 52h enters `PM_RUN`.
- R6: Writes to offset 09h of any value other than 48h or 52h leave the mode unchanged. Writes of those codes to other offsets also leave the mode unchanged.
- R7: With `cfg_pwrdn`=0, any write to offset 09h is discarded.
- R8: When `cfg_pwrdn` is 0 at a clock edge, the mode is `PM_RUN` after that edge.
- R9: A read of offset 0Dh returns `{7'b0, cfg_full_dec}`. A read of offset 09h returns 0 and does not change the mode.
- R10: Writes to offset 09h are claimed and act on the mode exactly as in R5, whatever the value of `pnp_act`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host I/O read strobe |
| io_wr | input | 1 | Host I/O write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data, 0 when the read is not accepted |
| io_claim | output | 1 | The block responds to the current I/O cycle |
| rom_rd | input | 1 | Boot-ROM memory read request |
| rom_rd_en | output | 1 | Boot-ROM read allowed |
| pnp_act | input | 1 | Logical-device activate bit |
| cfg_pwrdn | input | 1 | Power-down enable configuration bit |
| cfg_full_dec | input | 1 | Full 16-bit address decode select |
| act_n | output | 1 | Inverted activate status |
| clk_halt_req | output | 1 | Request to stop the core clock |
| clk_running | output | 1 | Core clock indicated running |

## Verification
A wrong mode state shows at `clk_halt_req` and `clk_running` one clock after the offending write or enable change. It also shows in bit 1 of the status register on the very next read. A faulty decode or gating path shows combinationally, in the same cycle, on `io_claim` and `io_rdata`. The tests therefore pair each write with a check one edge later and each read with a check before the edge. The deactivated cases check that the halt path stays live while every other path goes quiet.

// File: rtl/hostreg_pwrctl_pkg.sv
package hostreg_pwrctl_pkg;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 4;

    localparam logic [DATA_W-1:0] CODE_RUN  = 8'h52;
    localparam logic [DATA_W-1:0] CODE_HALT = 8'h48;

    localparam logic [OFS_W-1:0] OFS_STATUS = 4'h3;
    localparam logic [OFS_W-1:0] OFS_HALT   = 4'h9;
    localparam logic [OFS_W-1:0] OFS_CFGDEC = 4'hD;

    typedef enum logic [0:0] {
        PM_RUN  = 1'b0,
        PM_HALT = 1'b1
    } pm_state_t;
endpackage

// File: rtl/hostreg_addr_dec.sv
module hostreg_addr_dec #(
    parameter int ADDR_W = 16,
    parameter int RED_W  = 10,
    parameter int OFS_W  = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              full_dec,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs
);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam int RTAG  = RED_W - OFS_W;

    logic [TAG_W-1:0] bit_eq;

    // per-line compare of the tag field
    genvar gi;
    generate
        for (gi = 0; gi < TAG_W; gi++) begin : g_cmp
            assign bit_eq[gi] = (addr[gi+OFS_W] == BASE_ADDR[gi+OFS_W]);
        end
    endgenerate

    logic full_eq;
    logic red_eq;
    assign full_eq = &bit_eq;
    assign red_eq  = &bit_eq[RTAG-1:0];

    assign hit = full_dec ? full_eq : red_eq;
    assign ofs = addr[OFS_W-1:0];
endmodule

// File: rtl/hostreg_access_gate.sv
module hostreg_access_gate
    import hostreg_pwrctl_pkg::*;
(
    input  logic             hit,
    input  logic [OFS_W-1:0] ofs,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic             active,
    input  logic             rom_rd,
    output logic             claim,
    output logic             rd_ok,
    output logic             halt_wr,
    output logic             rom_en
);
    logic to_halt;
    assign to_halt = (ofs == OFS_HALT);

    // the halt-clock register stays reachable with the device inactive
    assign claim   = hit & (io_rd | io_wr) & (active | to_halt);
    assign rd_ok   = hit & io_rd & active;
    assign halt_wr = hit & io_wr & to_halt;
    assign rom_en  = rom_rd & active;
endmodule

// File: rtl/hostreg_pm_fsm.sv
module hostreg_pm_fsm
    import hostreg_pwrctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pwrdn_en,
    output logic              halt_req,
    output logic              running
);
    pm_state_t state_q;
    pm_state_t state_d;

    logic wr_ok;
    assign wr_ok = halt_wr & pwrdn_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_FORCE has priority, then T_HALT / T_WAKE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (pwrdn_en && wr_ok && wdata == CODE_HALT) begin
                    state_d = PM_HALT;                 // T_HALT
                end
            end
            PM_HALT: begin
                if (!pwrdn_en) begin
                    state_d = PM_RUN;                  // T_FORCE
                end else if (wr_ok && wdata == CODE_RUN) begin
                    state_d = PM_RUN;                  // T_WAKE
                end
            end
            default: state_d = PM_RUN;
        endcase
    end

    // outputs
    always_comb begin
        halt_req = 1'b0;
        running  = 1'b1;
        unique case (state_q)
            PM_RUN: begin
                halt_req = 1'b0;
                running  = 1'b1;
            end
            PM_HALT: begin
                halt_req = 1'b1;
                running  = 1'b0;
            end
            default: begin
                halt_req = 1'b0;
                running  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/hostreg_pwrctl.sv
module hostreg_pwrctl
    import hostreg_pwrctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RED_W  = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_claim,
    input  logic              rom_rd,
    output logic              rom_rd_en,
    input  logic              pnp_act,
    input  logic              cfg_pwrdn,
    input  logic              cfg_full_dec,
    output logic              act_n,
    output logic              clk_halt_req,
    output logic              clk_running
);
    logic             reg_hit;
    logic [OFS_W-1:0] reg_ofs;
    logic             rd_ok;
    logic             halt_wr;

    hostreg_addr_dec #(
        .ADDR_W   (ADDR_W),
        .RED_W    (RED_W),
        .OFS_W    (OFS_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .addr    (io_addr),
        .full_dec(cfg_full_dec),
        .hit     (reg_hit),
        .ofs     (reg_ofs)
    );

    hostreg_access_gate u_gate (
        .hit    (reg_hit),
        .ofs    (reg_ofs),
        .io_rd  (io_rd),
        .io_wr  (io_wr),
        .active (pnp_act),
        .rom_rd (rom_rd),
        .claim  (io_claim),
        .rd_ok  (rd_ok),
        .halt_wr(halt_wr),
        .rom_en (rom_rd_en)
    );

    hostreg_pm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt_wr (halt_wr),
        .wdata   (io_wdata),
        .pwrdn_en(cfg_pwrdn),
        .halt_req(clk_halt_req),
        .running (clk_running)
    );

    assign act_n = ~pnp_act;

    // read mux; the halt-clock offset is write-only and reads zero
    always_comb begin
        io_rdata = '0;
        if (rd_ok) begin
            unique case (reg_ofs)
                OFS_STATUS: io_rdata = {{(DATA_W-2){1'b0}}, clk_halt_req, act_n};
                OFS_CFGDEC: io_rdata = {{(DATA_W-1){1'b0}}, cfg_full_dec};
                default:    io_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/hostreg_pwrctl_chk.sv
module hostreg_pwrctl_chk
    import hostreg_pwrctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [OFS_W-1:0]  ofs,
    input logic [DATA_W-1:0] io_wdata,
    input logic              io_claim,
    input logic              rom_rd_en,
    input logic              pnp_act,
    input logic              cfg_pwrdn,
    input logic              act_n,
    input logic              clk_halt_req,
    input logic              clk_running
);
    logic code_wr;
    assign code_wr = io_wr & io_claim & (ofs == OFS_HALT) &
                     ((io_wdata == CODE_HALT) | (io_wdata == CODE_RUN));

    a_r1_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
        clk_halt_req != clk_running);

    a_r2_inv_act: assert property (@(posedge clk) disable iff (!rst_n)
        act_n == !pnp_act);

    a_r4_rom_block: assert property (@(posedge clk) disable iff (!rst_n)
        !pnp_act |-> !rom_rd_en);

    a_r5_halt_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pwrdn && io_wr && io_claim && ofs == OFS_HALT && io_wdata == CODE_HALT)
        |=> clk_halt_req);

    a_r5_run_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pwrdn && io_wr && io_claim && ofs == OFS_HALT && io_wdata == CODE_RUN)
        |=> clk_running);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pwrdn && !code_wr) |=> $stable(clk_halt_req));

    a_r8_force_run: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pwrdn |=> (clk_running && !clk_halt_req));

    a_r10_halt_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (!pnp_act && io_claim) |-> (ofs == OFS_HALT));
endmodule

bind hostreg_pwrctl hostreg_pwrctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_wr       (io_wr),
    .ofs         (reg_ofs),
    .io_wdata    (io_wdata),
    .io_claim    (io_claim),
    .rom_rd_en   (rom_rd_en),
    .pnp_act     (pnp_act),
    .cfg_pwrdn   (cfg_pwrdn),
    .act_n       (act_n),
    .clk_halt_req(clk_halt_req),
    .clk_running (clk_running)
);

// File: tb/hostreg_pwrctl_tb.sv
`timescale 1ns/1ps
module hostreg_pwrctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_claim;
    logic        rom_rd = 1'b0;
    logic        rom_rd_en;
    logic        pnp_act = 1'b1;
    logic        cfg_pwrdn = 1'b1;
    logic        cfg_full_dec = 1'b0;
    logic        act_n;
    logic        clk_halt_req;
    logic        clk_running;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hostreg_pwrctl u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_claim(io_claim), .rom_rd(rom_rd), .rom_rd_en(rom_rd_en),
        .pnp_act(pnp_act), .cfg_pwrdn(cfg_pwrdn), .cfg_full_dec(cfg_full_dec),
        .act_n(act_n), .clk_halt_req(clk_halt_req), .clk_running(clk_running)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_mode(input string tag, input bit halted);
        check({tag, " halt_req"}, {15'b0, clk_halt_req}, {15'b0, halted});
        check({tag, " running"},  {15'b0, clk_running},  {15'b0, !halted});
    endtask

    // write cycle: claim checked before the edge, result sampled after it
    task automatic io_write(input logic [15:0] a, input logic [7:0] d, input bit exp_claim,
                            input string tag);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        #1;
        check({tag, " claim"}, {15'b0, io_claim}, {15'b0, exp_claim});
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, input bit exp_claim, input logic [7:0] exp_d,
                           input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        check({tag, " claim"}, {15'b0, io_claim}, {15'b0, exp_claim});
        check({tag, " rdata"}, {8'b0, io_rdata}, {8'b0, exp_d});
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic t_reset;
        check_mode("R1 reset", 1'b0);
    endtask

    task automatic t_status;
        pnp_act = 1'b0; #1;
        check("R2 act_n inactive", {15'b0, act_n}, 16'd1);
        pnp_act = 1'b1; #1;
        check("R2 act_n active", {15'b0, act_n}, 16'd0);
        io_read(16'h0303, 1'b1, 8'h00, "R2 status run");
    endtask

    task automatic t_decode;
        cfg_full_dec = 1'b0;
        io_read(16'hF30D, 1'b1, 8'h00, "R3 reduced alias");
        io_read(16'h0313, 1'b0, 8'h00, "R3 reduced miss");
        cfg_full_dec = 1'b1;
        io_read(16'hF30D, 1'b0, 8'h00, "R3 full miss");
        io_read(16'h030D, 1'b1, 8'h01, "R9 cfgdec read");
        cfg_full_dec = 1'b0;
    endtask

    task automatic t_halt_wake;
        io_write(16'h0309, 8'h48, 1'b1, "R5 halt write");
        check_mode("R5 halted", 1'b1);
        io_read(16'h0303, 1'b1, 8'h02, "R2 status halted");
        io_read(16'h0309, 1'b1, 8'h00, "R9 halt reg read");
        check_mode("R9 read no effect", 1'b1);
        io_write(16'h0309, 8'h52, 1'b1, "R5 wake write");
        check_mode("R5 running", 1'b0);
    endtask

    task automatic t_ignore;
        io_write(16'h0309, 8'h48, 1'b1, "R6 setup");
        io_write(16'h0309, 8'h41, 1'b1, "R6 other code");
        check_mode("R6 kept halt", 1'b1);
        io_write(16'h0308, 8'h52, 1'b1, "R6 wrong offset");
        check_mode("R6 offset ignored", 1'b1);
        io_write(16'h0309, 8'h52, 1'b1, "R6 restore");
        io_write(16'h0309, 8'h68, 1'b1, "R6 lowercase h");
        check_mode("R6 kept run", 1'b0);
    endtask

    task automatic t_pwrdn_off;
        cfg_pwrdn = 1'b0;
        io_write(16'h0309, 8'h48, 1'b1, "R7 disabled write");
        check_mode("R7 discarded", 1'b0);
        cfg_pwrdn = 1'b1;
    endtask

    task automatic t_force;
        io_write(16'h0309, 8'h48, 1'b1, "R8 setup");
        check_mode("R8 halted", 1'b1);
        @(negedge clk);
        cfg_pwrdn = 1'b0;
        @(negedge clk);
        check_mode("R8 forced run", 1'b0);
        cfg_pwrdn = 1'b1;
    endtask

    task automatic t_inactive;
        @(negedge clk);
        pnp_act = 1'b0; rom_rd = 1'b1; #1;
        check("R4 rom blocked", {15'b0, rom_rd_en}, 16'd0);
        io_read(16'h030D, 1'b0, 8'h00, "R4 cfg read gated");
        io_read(16'h0303, 1'b0, 8'h00, "R4 status read gated");
        io_write(16'h0309, 8'h48, 1'b1, "R10 inactive halt");
        check_mode("R10 halted inactive", 1'b1);
        io_write(16'h0309, 8'h52, 1'b1, "R10 inactive wake");
        check_mode("R10 woken inactive", 1'b0);
        pnp_act = 1'b1; #1;
        check("R4 rom allowed", {15'b0, rom_rd_en}, 16'd1);
        rom_rd = 1'b0;
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("[TB] FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_decode();
        t_halt_wake();
        t_ignore();
        t_pwrdn_off();
        t_force();
        t_inactive();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule